// File: doc/BRIEF.md
# Strip Byte Stream Formatter

This block sits at the entry of a strip-detector readout channel. It takes a byte stream on a fast write clock in which address bytes and data bytes take turns. Each byte carries its own corruption flag. The block joins every address byte with the data byte that follows it, giving one 18-bit strip word. Two host-loaded lookup tables then act on each word, both indexed by strip address. A one-bit dead-strip table drops damaged strips. An eight-bit calibration table supplies the corrected value that replaces the raw data of every surviving strip.

Words that pass are written into a 64-entry FIFO with two clocks. A clustering stage drains the FIFO on a slower read clock, using a show-ahead read port. A write that arrives while the FIFO is full is discarded and sets a sticky overflow flag.

Byte pairing uses a two-state machine:
- `PS_WAIT_ADDR` is the reset state.
  - An address byte moves it to `PS_HOLD_ADDR` (transition *latch*).
  - A data byte keeps it in `PS_WAIT_ADDR` and is dropped (transition *orphan*).
- In `PS_HOLD_ADDR`:
  - A data byte emits a pair and returns to `PS_WAIT_ADDR` (transition *emit*).
  - A further address byte replaces the held one and stays in `PS_HOLD_ADDR` (transition *relatch*).

Top module: `strip_stream_formatter`

## Requirements
- R1: After reset, `rd_empty` is 1 and `overflow` is 0.
- R2: A data byte that directly follows an address byte yields one word. Its layout is bit 17 = address error flag, bits 16:9 = address, bit 8 = data error flag, bits 7:0 = data. Words leave in arrival order.
- R3: Both error flags of a byte pair are carried unchanged into the word, whatever their values.
- R4: A data byte received in `PS_WAIT_ADDR` is discarded and produces no word.
- R5: When two address bytes arrive back to back, the second replaces the first. The pair that follows uses the second address.
- R6: A strip whose dead-strip table entry (bit 0 of the loaded value) is 1 is not written to the FIFO.
- R7: For a good strip, bits 7:0 of the word equal the calibration table entry at the strip address, not the raw data byte.
- R8: Words cross to the read clock in order and without loss. Asserting `rd_en` while `rd_empty` is 1 removes nothing.
- R9: The FIFO holds 64 words. A valid word arriving while it is full is dropped, and `overflow` rises and stays high until write reset.
- R10: A host write issued with `host_we` (`host_sel` 0 = dead-strip table, 1 = calibration table) applies to strips arriving after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Byte stream and host clock |
| wr_rst_n | input | 1 | Asynchronous active-low reset, write side |
| byte_valid | input | 1 | A byte is present this cycle |
| byte_is_addr | input | 1 | 1 = address byte, 0 = data byte |
| byte_val | input | 8 | Byte value |
| byte_err | input | 1 | Corruption flag of this byte |
| host_we | input | 1 | Table write strobe |
| host_sel | input | 1 | 0 = dead-strip table, 1 = calibration table |
| host_addr | input | 8 | Table index (strip address) |
| host_wdata | input | 8 | Table value (dead-strip table uses bit 0) |
| overflow | output | 1 | Sticky: a word was lost to a full FIFO |
| rd_clk | input | 1 | Read clock |
| rd_rst_n | input | 1 | Asynchronous active-low reset, read side |
| rd_en | input | 1 | Pop the word shown on rd_data |
| rd_data | output | 18 | Head word of the FIFO |
| rd_empty | output | 1 | FIFO holds no word |

## Verification
The hardest condition to reach is the overflow edge. It needs 64 words accepted with no pop, followed by one more good strip, and dead strips silently thin the stream along the way. The bench stops its reader and picks 64 addresses that its own table model calls good. It checks that `overflow` is still low, then sends one extra good strip that it leaves out of the scoreboard. Draining afterwards must yield exactly the 64 expected words, with the flag still set.

// File: rtl/strip_fmt_pkg.sv
package strip_fmt_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W + 2;

    typedef struct packed {
        logic              addr_err;
        logic [BYTE_W-1:0] addr;
        logic              data_err;
        logic [BYTE_W-1:0] data;
    } strip_word_t;

    typedef enum logic {
        PS_WAIT_ADDR = 1'b0,
        PS_HOLD_ADDR = 1'b1
    } pair_state_t;
endpackage

// File: rtl/strip_pairer.sv
module strip_pairer
    import strip_fmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic              byte_is_addr,
    input  logic [BYTE_W-1:0] byte_val,
    input  logic              byte_err,
    output logic              pair_valid,
    output strip_word_t       pair_word
);
    pair_state_t       state_q, state_d;
    logic [BYTE_W-1:0] held_addr;
    logic              held_err;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_WAIT_ADDR: if (byte_valid && byte_is_addr) state_d = PS_HOLD_ADDR;
            PS_HOLD_ADDR: if (byte_valid && !byte_is_addr) state_d = PS_WAIT_ADDR;
            default:      state_d = PS_WAIT_ADDR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_WAIT_ADDR;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_addr  <= '0;
            held_err   <= 1'b0;
            pair_valid <= 1'b0;
            pair_word  <= '0;
        end else begin
            pair_valid <= 1'b0;
            if (byte_valid && byte_is_addr) begin
                held_addr <= byte_val;
                held_err  <= byte_err;
            end else if (byte_valid && state_q == PS_HOLD_ADDR) begin
                pair_valid <= 1'b1;
                pair_word  <= '{addr_err: held_err, addr: held_addr,
                               data_err: byte_err, data: byte_val};
            end
        end
    end

    AST_PAIR_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |=> !pair_valid); // R4

    AST_EMIT_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |-> $past(byte_valid && !byte_is_addr)); // R2
endmodule

// File: rtl/strip_lut.sv
module strip_lut #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int ENTRIES = 1 << AW;
    logic [DW-1:0] mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/strip_cdc_fifo.sv
module strip_cdc_fifo #(
    parameter int W    = 18,
    parameter int LOG2 = 6
) (
    input  logic         wr_clk,
    input  logic         wr_rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         overflow,
    input  logic         rd_clk,
    input  logic         rd_rst_n,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         rd_empty
);
    localparam int DEPTH = 1 << LOG2;
    localparam int PW    = LOG2 + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wbin, wgray, rbin, rgray;
    logic [PW-1:0] rq1, rq2, wq1, wq2;
    logic [PW-1:0] wbin_n, rbin_n;
    logic          full, wr_ok, rd_ok;

    assign full  = (wgray == {~rq2[PW-1:PW-2], rq2[PW-3:0]});
    assign wr_ok = wr_en && !full;
    assign wbin_n = wbin + PW'(wr_ok);

    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) begin
            wbin <= '0; wgray <= '0; rq1 <= '0; rq2 <= '0; overflow <= 1'b0;
        end else begin
            wbin  <= wbin_n;
            wgray <= wbin_n ^ (wbin_n >> 1);
            rq1   <= rgray;
            rq2   <= rq1;
            if (wr_en && full) overflow <= 1'b1;
        end
    end

    always_ff @(posedge wr_clk) begin
        if (wr_ok) mem[wbin[LOG2-1:0]] <= wr_data;
    end

    assign rd_empty = (rgray == wq2);
    assign rd_ok    = rd_en && !rd_empty;
    assign rbin_n   = rbin + PW'(rd_ok);
    assign rd_data  = mem[rbin[LOG2-1:0]];

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) begin
            rbin <= '0; rgray <= '0; wq1 <= '0; wq2 <= '0;
        end else begin
            rbin  <= rbin_n;
            rgray <= rbin_n ^ (rbin_n >> 1);
            wq1   <= wgray;
            wq2   <= wq1;
        end
    end

    AST_OVF_STICKY: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        overflow |=> overflow); // R9
    AST_FULL_BLOCKS_WRITE: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        full |=> $stable(wbin)); // R9
    AST_EMPTY_NO_POP: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_empty |=> $stable(rbin)); // R8
    AST_WGRAY_ONE_BIT: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $countones(wgray ^ $past(wgray)) <= 1); // R8
endmodule

// File: rtl/strip_stream_formatter.sv
module strip_stream_formatter
    import strip_fmt_pkg::*;
#(
    parameter int FIFO_LOG2 = 6
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              byte_valid,
    input  logic              byte_is_addr,
    input  logic [BYTE_W-1:0] byte_val,
    input  logic              byte_err,
    input  logic              host_we,
    input  logic              host_sel,
    input  logic [BYTE_W-1:0] host_addr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic              overflow,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_empty
);
    logic              pair_valid;
    strip_word_t       pair_word;
    logic              s1_valid;
    strip_word_t       s1_word;
    logic [0:0]        bad_q;
    logic [BYTE_W-1:0] gain_q;
    logic              fifo_wr;
    strip_word_t       fifo_word;

    strip_pairer u_pair (
        .clk(wr_clk), .rst_n(wr_rst_n),
        .byte_valid(byte_valid), .byte_is_addr(byte_is_addr),
        .byte_val(byte_val), .byte_err(byte_err),
        .pair_valid(pair_valid), .pair_word(pair_word)
    );

    strip_lut #(.AW(BYTE_W), .DW(1)) u_bad (
        .clk(wr_clk), .we(host_we && !host_sel), .waddr(host_addr),
        .wdata(host_wdata[0:0]), .raddr(pair_word.addr), .rdata(bad_q)
    );

    strip_lut #(.AW(BYTE_W), .DW(BYTE_W)) u_gain (
        .clk(wr_clk), .we(host_we && host_sel), .waddr(host_addr),
        .wdata(host_wdata), .raddr(pair_word.addr), .rdata(gain_q)
    );

    // Stage aligned with the one-cycle table read.
    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) begin
            s1_valid <= 1'b0;
            s1_word  <= '0;
        end else begin
            s1_valid <= pair_valid;
            s1_word  <= pair_word;
        end
    end

    always_comb begin
        fifo_word      = s1_word;
        fifo_word.data = gain_q;
        fifo_wr        = s1_valid && !bad_q[0];
    end

    strip_cdc_fifo #(.W(WORD_W), .LOG2(FIFO_LOG2)) u_fifo (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(fifo_wr),
        .wr_data(fifo_word), .overflow(overflow),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en),
        .rd_data(rd_data), .rd_empty(rd_empty)
    );

    AST_WRITE_FOLLOWS_PAIR: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        fifo_wr |-> $past(pair_valid)); // R6
endmodule

// File: tb/tb_strip_stream_formatter.sv
module tb_strip_stream_formatter;
    localparam int WR_PERIOD = 18;
    localparam int RD_PERIOD = 30;

    logic wr_clk = 0, rd_clk = 0;
    logic wr_rst_n = 0, rd_rst_n = 0;
    logic byte_valid = 0, byte_is_addr = 0, byte_err = 0;
    logic [7:0] byte_val = 0;
    logic host_we = 0, host_sel = 0;
    logic [7:0] host_addr = 0, host_wdata = 0;
    logic overflow, rd_empty;
    logic rd_en = 0;
    logic [17:0] rd_data;

    always #(WR_PERIOD/2) wr_clk = ~wr_clk;
    always #(RD_PERIOD/2) rd_clk = ~rd_clk;

    strip_stream_formatter dut (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .byte_valid(byte_valid),
        .byte_is_addr(byte_is_addr), .byte_val(byte_val), .byte_err(byte_err),
        .host_we(host_we), .host_sel(host_sel), .host_addr(host_addr),
        .host_wdata(host_wdata), .overflow(overflow), .rd_clk(rd_clk),
        .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty)
    );

    int checks = 0, errors = 0;
    string tag = "R2";
    logic [17:0] expq[$];
    bit model_bad[256];
    logic [7:0] model_gain[256];
    bit drain = 0, force_pop = 0;

    task automatic chk(string req, logic [17:0] act, logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pops scoreboard and compares while draining.
    initial forever begin
        @(negedge rd_clk);
        rd_en = force_pop;
        if (drain && rd_rst_n && !rd_empty) begin
            checks++;
            if (expq.size() == 0) begin
                errors++;
                $display("FAIL %s actual=%h expected=<none>", tag, rd_data);
            end else begin
                logic [17:0] e;
                e = expq.pop_front();
                if (rd_data !== e) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", tag, rd_data, e);
                end
            end
            rd_en = 1;
        end
    end

    task automatic host_write(logic sel, logic [7:0] a, logic [7:0] d);
        @(negedge wr_clk);
        host_we = 1; host_sel = sel; host_addr = a; host_wdata = d;
        if (sel) model_gain[a] = d; else model_bad[a] = d[0];
        @(negedge wr_clk);
        host_we = 0;
    endtask

    task automatic send_byte(logic is_addr, logic [7:0] v, logic err);
        @(negedge wr_clk);
        byte_valid = 1; byte_is_addr = is_addr; byte_val = v; byte_err = err;
    endtask

    task automatic idle(int n);
        @(negedge wr_clk);
        byte_valid = 0;
        repeat (n) @(negedge wr_clk);
    endtask

    task automatic send_strip(logic [7:0] a, logic [7:0] d, logic ae, logic de, bit push);
        send_byte(1, a, ae);
        send_byte(0, d, de);
        if (push && !model_bad[a]) expq.push_back({ae, a, de, model_gain[a]});
    endtask

    task automatic wait_drain(string req);
        idle(4);
        for (int i = 0; i < 3000 && expq.size() != 0; i++) @(negedge rd_clk);
        repeat (8) @(negedge rd_clk);
        chk(req, 18'(expq.size()), 18'd0);
        chk(req, {17'd0, rd_empty}, 18'd1);
    endtask

    initial begin
        repeat (150000) @(posedge wr_clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge wr_clk);
        wr_rst_n = 1; rd_rst_n = 1;
        repeat (2) @(negedge rd_clk);
        // R1 reset state
        chk("R1", {17'd0, rd_empty}, 18'd1);
        chk("R1", {17'd0, overflow}, 18'd0);

        for (int a = 0; a < 256; a++) begin
            host_write(0, 8'(a), {7'd0, (a % 7 == 3)});
            host_write(1, 8'(a), 8'(a) ^ 8'h5A);
        end
        drain = 1;

        tag = "R2 R7";  // layout and calibrated data
        send_strip(8'h01, 8'hC3, 0, 0, 1);
        send_strip(8'h20, 8'h00, 0, 0, 1);
        send_strip(8'hFF, 8'h7E, 0, 0, 1);
        idle(2);
        send_strip(8'h44, 8'h11, 0, 0, 1);
        wait_drain("R2");

        tag = "R3";  // error flags carried
        send_strip(8'h05, 8'h10, 1, 0, 1);
        send_strip(8'h06, 8'h20, 0, 1, 1);
        send_strip(8'h07, 8'h30, 1, 1, 1);
        wait_drain("R3");

        tag = "R6";  // dead strips dropped (3 and 10 are dead)
        send_strip(8'h03, 8'h55, 0, 0, 1);
        send_strip(8'h08, 8'h56, 0, 0, 1);
        send_strip(8'h0A, 8'h57, 1, 1, 1);
        send_strip(8'h09, 8'h58, 0, 0, 1);
        wait_drain("R6");

        tag = "R4";  // orphan data bytes ignored
        send_byte(0, 8'h99, 0);
        send_byte(0, 8'h98, 1);
        send_strip(8'h0C, 8'h40, 0, 0, 1);
        send_byte(0, 8'h97, 0);
        wait_drain("R4");

        tag = "R5";  // second address replaces first
        send_byte(1, 8'h30, 1);
        send_byte(1, 8'h31, 0);
        send_byte(0, 8'h22, 0);
        expq.push_back({1'b0, 8'h31, 1'b0, model_gain[8'h31]});
        wait_drain("R5");

        tag = "R10";  // table updates apply to later strips
        host_write(1, 8'h10, 8'hEE);
        host_write(0, 8'h11, 8'h01);
        host_write(0, 8'h03, 8'h00);
        send_strip(8'h10, 8'h01, 0, 0, 1);
        send_strip(8'h11, 8'h02, 0, 0, 1);
        send_strip(8'h03, 8'h03, 0, 0, 1);
        wait_drain("R10");

        tag = "R8";  // popping while empty removes nothing
        force_pop = 1;
        repeat (6) @(negedge rd_clk);
        send_strip(8'h12, 8'h04, 0, 0, 1);
        send_strip(8'h13, 8'h05, 1, 0, 1);
        wait_drain("R8");
        force_pop = 0;

        tag = "R9";  // fill to 64, then one extra word is lost
        drain = 0;
        begin
            int n = 0;
            for (int a = 32; n < 64; a++) begin
                if (!model_bad[a]) begin
                    send_strip(8'(a), 8'(n), 0, 0, 1);
                    n++;
                end
            end
        end
        idle(10);
        chk("R9", {17'd0, overflow}, 18'd0);
        send_strip(8'h20, 8'hAB, 0, 0, 0);
        idle(6);
        chk("R9", {17'd0, overflow}, 18'd1);
        drain = 1;
        wait_drain("R9");
        chk("R9", {17'd0, overflow}, 18'd1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule